// File: doc/BRIEF.md
# Matrix-Multiply Operand Index Sequencer

This block walks the iteration space of a matrix multiply-accumulate Z = X * Y, where X is a×b, Y is b×c and Z is a×c. On each accepted step it presents three flattened element indices: one into X, one into Y and one into the result Z. Every matrix is stored row-major, so element numbers run left to right along a row and then from row to row. A downstream datapath uses the three indices to fetch both operands and to read-modify-write the accumulator. The multiplier, the register file and the tiling of large matrices live elsewhere.

A start pulse latches the three dimensions and a loop-order select. Order 0 is the conventional order: the inner index moves fastest, so the same result element is hit on b consecutive steps. Order 1 moves the result column fastest, then the result row, then the inner index. In that order the result index changes on every step, which keeps back-to-back accumulates off the same element. A ready input stalls the walk. A done flag marks the final triple. The block rejects any configuration whose step count exceeds the limit and emits no steps for it. Every index is produced by incremental adds.

Top module: `mm_index_seq`

## Requirements
- R1: After reset, valid, done and rejected are low and all three index outputs are 0.
- R2: When idle, a start pulse latches dim_a (a), dim_b (b), dim_c (c) and order_sel. For an accepted non-empty configuration, valid rises in the cycle after the start edge with indices (0,0,0). Later changes on the dimension and order inputs have no effect on the running walk.
- R3: Each emitted triple for loop counters i<a, j<b, k<c equals X=i*b+j, Y=j*c+k, Z=i*c+k.
- R4: With order_sel=0, j varies fastest, then k, then i. For a=2, b=3, c=2 the sequence is (0,0,0),(1,2,0),(2,4,0),(0,1,1),(1,3,1),(2,5,1),(3,0,2),(4,2,2),(5,4,2),(3,1,3),(4,3,3),(5,5,3).
- R5: With order_sel=1, k varies fastest, then i, then j. Z differs from the previous step on every step when a*c>1. For a=2, b=3, c=2 the sequence is (0,0,0),(0,1,1),(3,0,2),(3,1,3),(1,2,0),(1,3,1),(4,2,2),(4,3,3),(2,4,0),(2,5,1),(5,4,2),(5,5,3).
- R6: A step is taken only on a clock edge where valid and ready are both high. While ready is low, valid stays high and the indices hold.
- R7: done is high exactly in the cycles in which valid carries the last triple. In the cycle after that triple is accepted, valid and done are low.
- R8: If any latched dimension is zero, no triple is emitted. done pulses high for exactly one cycle, in the cycle after the start edge, with valid low.
- R9: If a*b*c exceeds 127, rejected pulses high for one cycle after the start edge, with valid and done low. A product of exactly 127 is accepted and runs all 127 steps.
- R10: A start pulse while valid is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Latch configuration and begin a walk (idle only) |
| order_sel | input | 1 | 0 = conventional order, 1 = result-index-rotating order |
| dim_a | input | 7 | Rows of X and of Z |
| dim_b | input | 7 | Shared inner dimension |
| dim_c | input | 7 | Columns of Y and of Z |
| ready | input | 1 | Consumer accepts the current triple |
| valid | output | 1 | A triple is being presented |
| done | output | 1 | Current triple is the last one, or an empty walk finished |
| rejected | output | 1 | One-cycle pulse: configuration over the step limit |
| x_idx | output | 7 | Flattened X element index |
| y_idx | output | 7 | Flattened Y element index |
| z_idx | output | 7 | Flattened Z element index |

## Verification
The bench builds the block with its default parameters: 7-bit dimensions, 7-bit indices and a limit of 127 steps. These defaults make both sides of the limit reachable in short runs. A 127×1×1 or 1×127×1 walk drives the indices up to 126 at full width, and an 8×4×4 request sits one step over the limit. Small shapes with a pseudo-random stall pattern, in both loop orders, cover the wrap of each counter. They also cover the mid-run start and input changes that must be ignored.

// File: rtl/mm_index_seq.sv
module mm_index_seq #(
  parameter int DIM_W     = 7,
  parameter int IDX_W     = 7,
  parameter int MAX_STEPS = 127
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             order_sel,
  input  logic [DIM_W-1:0] dim_a,
  input  logic [DIM_W-1:0] dim_b,
  input  logic [DIM_W-1:0] dim_c,
  input  logic             ready,
  output logic             valid,
  output logic             done,
  output logic             rejected,
  output logic [IDX_W-1:0] x_idx,
  output logic [IDX_W-1:0] y_idx,
  output logic [IDX_W-1:0] z_idx
);
  localparam int PROD_W = 3 * DIM_W;
  localparam logic [DIM_W-1:0]  D1 = DIM_W'(1);
  localparam logic [IDX_W-1:0]  I1 = IDX_W'(1);
  localparam logic [PROD_W-1:0] LIMIT = PROD_W'(MAX_STEPS);

  logic             busy, ord_q, zero_q, rej_q;
  logic [DIM_W-1:0] na, nb, nc, ci, cj, ck;
  logic [IDX_W-1:0] x, y, z, xb, yb;

  logic [PROD_W-1:0] total;
  logic cfg_zero, cfg_big, last_i, last_j, last_k, last;

  assign total    = PROD_W'(dim_a) * PROD_W'(dim_b) * PROD_W'(dim_c);
  assign cfg_zero = (dim_a == '0) || (dim_b == '0) || (dim_c == '0);
  assign cfg_big  = total > LIMIT;

  assign last_i = ci == na - D1;
  assign last_j = cj == nb - D1;
  assign last_k = ck == nc - D1;
  assign last   = last_i && last_j && last_k;

  assign valid    = busy;
  assign done     = (busy && last) || zero_q;
  assign rejected = rej_q;
  assign x_idx    = x;
  assign y_idx    = y;
  assign z_idx    = z;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; ord_q <= 1'b0; zero_q <= 1'b0; rej_q <= 1'b0;
      na <= '0; nb <= '0; nc <= '0;
      ci <= '0; cj <= '0; ck <= '0;
      x <= '0; y <= '0; z <= '0; xb <= '0; yb <= '0;
    end else begin
      zero_q <= 1'b0;
      rej_q  <= 1'b0;
      if (!busy) begin
        if (start) begin
          na <= dim_a; nb <= dim_b; nc <= dim_c; ord_q <= order_sel;
          ci <= '0; cj <= '0; ck <= '0;
          x <= '0; y <= '0; z <= '0; xb <= '0; yb <= '0;
          if (cfg_zero)     zero_q <= 1'b1;
          else if (cfg_big) rej_q  <= 1'b1;
          else              busy   <= 1'b1;
        end
      end else if (ready) begin
        if (last) begin
          busy <= 1'b0;
        end else if (!ord_q) begin
          if (!last_j) begin
            cj <= cj + D1;
            x  <= x + I1;
            y  <= y + IDX_W'(nc);
          end else if (!last_k) begin
            cj <= '0;
            ck <= ck + D1;
            x  <= xb;
            y  <= IDX_W'(ck) + I1;
            z  <= z + I1;
          end else begin
            cj <= '0;
            ck <= '0;
            ci <= ci + D1;
            xb <= xb + IDX_W'(nb);
            x  <= xb + IDX_W'(nb);
            y  <= '0;
            z  <= z + I1;
          end
        end else begin
          if (!last_k) begin
            ck <= ck + D1;
            y  <= y + I1;
            z  <= z + I1;
          end else if (!last_i) begin
            ck <= '0;
            ci <= ci + D1;
            x  <= x + IDX_W'(nb);
            y  <= yb;
            z  <= z + I1;
          end else begin
            ck <= '0;
            ci <= '0;
            cj <= cj + D1;
            x  <= IDX_W'(cj) + I1;
            yb <= yb + IDX_W'(nc);
            y  <= yb + IDX_W'(nc);
            z  <= '0;
          end
        end
      end
    end
  end

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !ready |=> busy && $stable(x) && $stable(y) && $stable(z));

  // R5
  rotate_z_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && ready && ord_q && !last && (na != D1 || nc != D1) |=> z != $past(z));

  // R4
  conv_z_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && ready && !ord_q && !last_j |=> busy && z == $past(z));

  // R7
  last_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && ready && last |=> !valid && !done);

  // R8
  empty_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_q |-> !busy && !rej_q);

  // R9
  reject_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rej_q |-> !valid && !done);

  // R10
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !ready |=> $stable(na) && $stable(nb) && $stable(nc) && $stable(ord_q));
endmodule

// File: tb/mm_index_seq_bench.sv
`timescale 1ns/1ps
module mm_index_seq_bench;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, order_sel = 1'b0, ready = 1'b1;
  logic [6:0] dim_a = '0, dim_b = '0, dim_c = '0;
  logic valid, done, rejected;
  logic [6:0] x_idx, y_idx, z_idx;
  int checks = 0, failures = 0;
  bit finished = 1'b0;
  logic [15:0] lf = 16'hACE1;

  always #5 clk = ~clk;

  mm_index_seq u_mm_index_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .order_sel(order_sel),
    .dim_a(dim_a), .dim_b(dim_b), .dim_c(dim_c), .ready(ready),
    .valid(valid), .done(done), .rejected(rejected),
    .x_idx(x_idx), .y_idx(y_idx), .z_idx(z_idx));

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic run(int a, int b, int c, bit ord, bit stall, bit disturb);
    int qx[$], qy[$], qz[$];
    int n = 0;
    int prev_z = -1;
    string tag = ord ? "R5" : "R4";
    if (!ord) begin
      for (int i = 0; i < a; i++) for (int k = 0; k < c; k++) for (int j = 0; j < b; j++) begin
        qx.push_back(i*b+j); qy.push_back(j*c+k); qz.push_back(i*c+k);
      end
    end else begin
      for (int j = 0; j < b; j++) for (int i = 0; i < a; i++) for (int k = 0; k < c; k++) begin
        qx.push_back(i*b+j); qy.push_back(j*c+k); qz.push_back(i*c+k);
      end
    end
    @(negedge clk);
    start = 1'b1; dim_a = 7'(a); dim_b = 7'(b); dim_c = 7'(c); order_sel = ord;
    @(negedge clk);
    start = 1'b0;
    if (disturb) begin
      dim_a = 7'd3; dim_b = 7'd1; dim_c = 7'd9; order_sel = !ord;   // R2 ignored
    end
    chk("R2", "first valid", int'(valid), 1);
    while (qx.size() > 0 && n < 2000) begin
      chk(tag, "valid", int'(valid), 1);
      chk({tag, "/R3"}, "x_idx", int'(x_idx), qx[0]);
      chk({tag, "/R3"}, "y_idx", int'(y_idx), qy[0]);
      chk({tag, "/R3"}, "z_idx", int'(z_idx), qz[0]);
      chk("R7", "done", int'(done), int'(qx.size() == 1));
      if (ord && a*c > 1 && prev_z >= 0 && ready)
        chk("R5", "z changed", int'(int'(z_idx) != prev_z), 1);
      if (disturb && n == 3) begin
        start = 1'b1; dim_a = 7'd0;                                   // R10 ignored
      end
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      ready = stall ? (lf[0] | lf[3]) : 1'b1;                        // R6 stalls
      if (ready) begin
        prev_z = int'(z_idx);
        void'(qx.pop_front()); void'(qy.pop_front()); void'(qz.pop_front());
      end
      @(negedge clk);
      start = 1'b0;
      n++;
    end
    chk("R7", "valid after last", int'(valid), 0);
    chk("R7", "done after last", int'(done), 0);
    ready = 1'b1;
  endtask

  task automatic run_special(int a, int b, int c, bit empty);
    string tag = empty ? "R8" : "R9";
    @(negedge clk);
    start = 1'b1; dim_a = 7'(a); dim_b = 7'(b); dim_c = 7'(c); order_sel = 1'b0;
    @(negedge clk);
    start = 1'b0;
    chk(tag, "done pulse", int'(done), int'(empty));
    chk(tag, "rejected pulse", int'(rejected), int'(!empty));
    chk(tag, "valid", int'(valid), 0);
    @(negedge clk);
    chk(tag, "done after", int'(done), 0);
    chk(tag, "rejected after", int'(rejected), 0);
    chk(tag, "valid after", int'(valid), 0);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "valid", int'(valid), 0);
    chk("R1", "done", int'(done), 0);
    chk("R1", "rejected", int'(rejected), 0);
    chk("R1", "indices", int'({x_idx, y_idx, z_idx}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    run(2, 3, 2, 1'b0, 1'b0, 1'b0);
    run(2, 3, 2, 1'b1, 1'b0, 1'b0);
    run(2, 3, 2, 1'b1, 1'b1, 1'b1);
    run(2, 3, 2, 1'b0, 1'b1, 1'b1);
    run(3, 4, 5, 1'b0, 1'b1, 1'b0);
    run(4, 3, 5, 1'b1, 1'b1, 1'b0);
    run(1, 1, 1, 1'b1, 1'b0, 1'b0);
    run(1, 5, 1, 1'b1, 1'b1, 1'b0);
    run(127, 1, 1, 1'b1, 1'b0, 1'b0);
    run(1, 127, 1, 1'b0, 1'b1, 1'b0);
    run(1, 1, 127, 1'b0, 1'b0, 1'b0);
    run_special(0, 3, 2, 1'b1);
    run_special(3, 4, 0, 1'b1);
    run_special(8, 4, 4, 1'b0);
    run_special(127, 127, 127, 1'b0);
    run(5, 5, 5, 1'b1, 1'b1, 1'b0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule